// File: doc/BRIEF.md
# Task Switch Descriptor Validator

This block sits in the task-switch path of a protected-mode core. When a jump, call, interrupt or nested return asks for a task switch, the core fetches the 8-byte descriptor that the request names and hands it to this block. The block classifies the descriptor, applies the privilege, presence, size, table and busy rules, and answers with the task-state segment base and byte limit plus the busy-bit and back-link actions that the core must carry out. When no rule is broken it returns fault code 0; otherwise it returns a fault code and no actions. Saving and restoring registers, memory access and paging belong to the core. A task switch pushes nothing on any stack, so the block produces no stack action.

A task gate is handled in two beats. The gate beat is checked against the caller's privilege. The block then raises a fetch request that carries the TSS selector taken from the gate, and waits for the core to return the descriptor named by that selector on the same input channel. The inner beat skips the privilege test: the selector's requested privilege and the target descriptor's privilege level play no part. A direct TSS descriptor, or a nested return, is answered after one beat.

All three data paths use valid/ready. A beat moves when valid and ready are both high at a rising edge. `in_ready` is high only while the block is idle or waiting for the inner beat of a gate. `fet_valid` and `res_valid`, once raised, stay high with their payload unchanged until the matching ready is seen, and no new input is taken while either is pending. The producer may hold `in_valid` for any number of cycles.

Top module: `task_switch_gatekeeper`

## Requirements
- R1: Exactly one of `in_ready`, `fet_valid`, `res_valid` is high in every cycle. After reset `in_ready` is high. A raised `fet_valid` or `res_valid` keeps its payload unchanged until its ready is sampled high.
- R2: Timing. A result is valid in the cycle after a direct beat or an inner beat is accepted. A fetch request is valid in the cycle after an accepted gate beat that breaks no rule.
- R3: Descriptor layout. The base is {bits 63:56, 39:32, 31:16}. The 20-bit raw limit is {bits 51:48, 15:0}. When bit 55 is 0, the byte limit is the raw limit; when bit 55 is 1, it is raw*4096+4095. A successful result carries this base and byte limit.
- R4: For a direct beat of a jump, call or return, `in_ti`=1 gives fault 5. For an inner beat, bit 2 of the gate's selector being 1 gives fault 5. `in_ti` is ignored for interrupts and for gate beats.
- R5: Bit 44 selects the descriptor kind. A TSS has bit 44 = 0 and bits 43:40 = 10B1. A gate has bit 44 = 0 and bits 43:40 = 0101. Fault 1 is raised for an interrupt (kind 2) whose beat is not a gate, for a return (kind 3) given a non-TSS, and for any direct or inner beat that is not a TSS. Kinds: 0 jump, 1 call, 2 interrupt, 3 nested return.
- R6: On a gate beat, and on a direct TSS beat for kinds 0 and 1, fault 2 is raised unless the DPL (bits 46:45) is numerically at least `in_cpl` and at least `in_rpl`. The inner beat and returns are not checked.
- R7: A descriptor with present bit 47 equal to 0 gives fault 3. This applies to the gate beat and to the TSS beat.
- R8: A TSS whose byte limit is below `MIN_TSS_LIMIT` (0x67) gives fault 4.
- R9: Busy is bit 41. Entering (kinds 0, 1, 2) a TSS that is already busy gives fault 6. A return to a TSS that is not busy gives fault 7.
- R10: A successful result sets the actions as follows. Kind 0: set incoming busy and clear outgoing busy. Kinds 1 and 2: set incoming busy and write the back link. Kind 3: clear outgoing busy only. For a gate path, the kind is the one given with the gate beat.
- R11: A beat breaking several rules reports the first broken rule in this order: gate privilege, gate presence, interrupt type, table, type, privilege, presence, limit, busy. A fault result has all actions 0 and base and limit 0.
- R12: `fet_sel` carries bits 31:16 of the accepted gate beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor beat offered |
| in_ready | output | 1 | Block takes a beat this cycle |
| in_desc | input | 64 | Descriptor word |
| in_kind | input | 2 | Trigger: 0 jump, 1 call, 2 interrupt, 3 nested return (ignored on inner beat) |
| in_cpl | input | 2 | Current privilege level (ignored on inner beat) |
| in_rpl | input | 2 | Requested privilege of the caller's selector (ignored on inner beat) |
| in_ti | input | 1 | Selector names the local table (ignored on inner beat) |
| fet_valid | output | 1 | Second fetch requested |
| fet_ready | input | 1 | Core takes the fetch request |
| fet_sel | output | 16 | Selector to fetch |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Core takes the result |
| res_fault | output | 3 | 0 none, 1 type, 2 privilege, 3 not present, 4 too short, 5 local table, 6 busy, 7 not busy |
| res_base | output | 32 | TSS base (0 on fault) |
| res_limit | output | 32 | TSS byte limit (0 on fault) |
| res_set_in_busy | output | 1 | Set busy on incoming TSS descriptor |
| res_clr_out_busy | output | 1 | Clear busy on outgoing TSS descriptor |
| res_write_link | output | 1 | Write previous-task link into incoming TSS |

## Verification
A result is due in the first cycle after its direct or inner beat is accepted, and a fetch request in the first cycle after its gate beat is accepted. Each stays up for as many cycles as the bench keeps the matching ready low. The bench model advances its own state at every rising edge from the handshake inputs alone. At every falling edge it compares the three valid/ready outputs and, whenever it expects a valid, the full payload. A result that arrives a cycle early or late therefore fails in that very cycle. The back-pressure pattern on both ready inputs varies, so the stall paths are exercised alongside the rule checks.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  localparam int DESC_W = 64;
  localparam int ADDR_W = 32;
  localparam int LIM_W  = 20;
  localparam int SEL_W  = 16;

  typedef enum logic [1:0] {
    SW_JMP  = 2'd0,
    SW_CALL = 2'd1,
    SW_INT  = 2'd2,
    SW_IRET = 2'd3
  } sw_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_TYPE   = 3'd1,
    FLT_PRIV   = 3'd2,
    FLT_ABSENT = 3'd3,
    FLT_SHORT  = 3'd4,
    FLT_LOCAL  = 3'd5,
    FLT_BUSY   = 3'd6,
    FLT_IDLE   = 3'd7
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RES   = 2'd3
  } gk_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  lim;
    logic              gran;
    logic [1:0]        dpl;
    logic              present;
    logic              is_tss;
    logic              is_gate;
    logic              busy;
    logic [SEL_W-1:0]  gate_sel;
  } desc_f_t;
endpackage

// File: rtl/tsg_decode.sv
module tsg_decode
  import tsg_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  output desc_f_t           f
);
  logic unused_resv;
  assign unused_resv = ^desc[54:52];

  always_comb begin
    f.base     = {desc[63:56], desc[39:32], desc[31:16]};
    f.lim      = {desc[51:48], desc[15:0]};
    f.gran     = desc[55];
    f.dpl      = desc[46:45];
    f.present  = desc[47];
    f.is_tss   = !desc[44] && desc[43] && !desc[42] && desc[40];
    f.is_gate  = !desc[44] && (desc[43:40] == 4'b0101);
    f.busy     = desc[41];
    f.gate_sel = desc[31:16];
  end
endmodule

// File: rtl/tsg_rules.sv
module tsg_rules
  import tsg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MIN_LIMIT  = 32'h67,
  parameter int                GRAN_SHIFT = 12
) (
  input  desc_f_t           f,
  input  sw_kind_e          kind,
  input  logic [1:0]        cpl,
  input  logic [1:0]        rpl,
  input  logic              ti,
  input  logic              inner,
  output fault_e            fault,
  output logic              go_fetch,
  output logic [ADDR_W-1:0] eff_limit
);
  localparam logic [ADDR_W-1:0] GRAN_FILL = (ADDR_W'(1) << GRAN_SHIFT) - ADDR_W'(1);

  logic priv_ok;
  logic entering;

  assign eff_limit = f.gran ? ((ADDR_W'(f.lim) << GRAN_SHIFT) | GRAN_FILL)
                            : ADDR_W'(f.lim);
  assign priv_ok   = (f.dpl >= cpl) && (f.dpl >= rpl);
  assign entering  = (kind != SW_IRET);

  always_comb begin
    fault    = FLT_NONE;
    go_fetch = 1'b0;
    if (!inner && f.is_gate && entering) begin
      if (!priv_ok)        fault = FLT_PRIV;
      else if (!f.present) fault = FLT_ABSENT;
      else                 go_fetch = 1'b1;
    end else if (!inner && kind == SW_INT) begin
      fault = FLT_TYPE;
    end else if (ti) begin
      fault = FLT_LOCAL;
    end else if (!f.is_tss) begin
      fault = FLT_TYPE;
    end else if (!inner && entering && !priv_ok) begin
      fault = FLT_PRIV;
    end else if (!f.present) begin
      fault = FLT_ABSENT;
    end else if (eff_limit < MIN_LIMIT) begin
      fault = FLT_SHORT;
    end else if (entering && f.busy) begin
      fault = FLT_BUSY;
    end else if (!entering && !f.busy) begin
      fault = FLT_IDLE;
    end
  end
endmodule

// File: rtl/tsg_actions.sv
module tsg_actions
  import tsg_pkg::*;
(
  input  sw_kind_e kind,
  input  logic     ok,
  output logic     set_in,
  output logic     clr_out,
  output logic     link
);
  always_comb begin
    set_in  = 1'b0;
    clr_out = 1'b0;
    link    = 1'b0;
    if (ok) begin
      unique case (kind)
        SW_JMP:  begin set_in = 1'b1; clr_out = 1'b1; end
        SW_CALL,
        SW_INT:  begin set_in = 1'b1; link = 1'b1; end
        SW_IRET: clr_out = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/task_switch_gatekeeper.sv
module task_switch_gatekeeper
  import tsg_pkg::*;
#(
  parameter logic [31:0] MIN_TSS_LIMIT = 32'h67,
  parameter int          GRAN_SHIFT    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DESC_W-1:0] in_desc,
  input  logic [1:0]        in_kind,
  input  logic [1:0]        in_cpl,
  input  logic [1:0]        in_rpl,
  input  logic              in_ti,
  output logic              fet_valid,
  input  logic              fet_ready,
  output logic [SEL_W-1:0]  fet_sel,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [2:0]        res_fault,
  output logic [ADDR_W-1:0] res_base,
  output logic [ADDR_W-1:0] res_limit,
  output logic              res_set_in_busy,
  output logic              res_clr_out_busy,
  output logic              res_write_link
);
  gk_state_e         state;
  sw_kind_e          held_kind;
  logic [SEL_W-1:0]  held_sel;

  desc_f_t           fields;
  sw_kind_e          kind_mux;
  logic              ti_mux;
  logic              inner;
  fault_e            fault;
  logic              go_fetch;
  logic [ADDR_W-1:0] eff_limit;
  logic              ok;
  logic              act_set, act_clr, act_link;
  logic              accept;

  assign inner    = (state == ST_WAIT);
  assign kind_mux = inner ? held_kind : sw_kind_e'(in_kind);
  assign ti_mux   = inner ? held_sel[2] : in_ti;
  assign ok       = (fault == FLT_NONE);

  assign in_ready  = (state == ST_IDLE) || (state == ST_WAIT);
  assign fet_valid = (state == ST_FETCH);
  assign res_valid = (state == ST_RES);
  assign fet_sel   = held_sel;
  assign accept    = in_valid && in_ready;

  tsg_decode u_decode (
    .desc (in_desc),
    .f    (fields)
  );

  tsg_rules #(
    .MIN_LIMIT  (MIN_TSS_LIMIT),
    .GRAN_SHIFT (GRAN_SHIFT)
  ) u_rules (
    .f         (fields),
    .kind      (kind_mux),
    .cpl       (in_cpl),
    .rpl       (in_rpl),
    .ti        (ti_mux),
    .inner     (inner),
    .fault     (fault),
    .go_fetch  (go_fetch),
    .eff_limit (eff_limit)
  );

  tsg_actions u_actions (
    .kind    (kind_mux),
    .ok      (ok),
    .set_in  (act_set),
    .clr_out (act_clr),
    .link    (act_link)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state            <= ST_IDLE;
      held_kind        <= SW_JMP;
      held_sel         <= '0;
      res_fault        <= '0;
      res_base         <= '0;
      res_limit        <= '0;
      res_set_in_busy  <= 1'b0;
      res_clr_out_busy <= 1'b0;
      res_write_link   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE, ST_WAIT: begin
          if (accept) begin
            if (!inner && go_fetch) begin
              held_kind <= kind_mux;
              held_sel  <= fields.gate_sel;
              state     <= ST_FETCH;
            end else begin
              res_fault        <= fault;
              res_base         <= ok ? fields.base : '0;
              res_limit        <= ok ? eff_limit : '0;
              res_set_in_busy  <= act_set;
              res_clr_out_busy <= act_clr;
              res_write_link   <= act_link;
              state            <= ST_RES;
            end
          end
        end
        ST_FETCH: if (fet_ready) state <= ST_WAIT;
        ST_RES:   if (res_ready) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsg_checker.sv
module tsg_checker #(
  parameter logic [31:0] MIN_TSS_LIMIT = 32'h67
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [63:0] in_desc,
  input logic        fet_valid,
  input logic        fet_ready,
  input logic [15:0] fet_sel,
  input logic        res_valid,
  input logic        res_ready,
  input logic [2:0]  res_fault,
  input logic [31:0] res_base,
  input logic [31:0] res_limit,
  input logic        res_set_in_busy,
  input logic        res_clr_out_busy,
  input logic        res_write_link
);
  // R1
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({in_ready, fet_valid, res_valid}) == 1);

  // R1
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid &&
      $stable({res_fault, res_base, res_limit, res_set_in_busy, res_clr_out_busy, res_write_link}));

  // R1
  fet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fet_valid && !fet_ready |=> fet_valid && $stable(fet_sel));

  // R2
  answer_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> res_valid || fet_valid);

  // R12
  fetch_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fet_valid) |-> fet_sel == $past(in_desc[31:16]));

  // R8
  min_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault == 3'd0 |-> res_limit >= MIN_TSS_LIMIT);

  // R11
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault != 3'd0 |->
      !(res_set_in_busy || res_clr_out_busy || res_write_link) &&
      res_base == 32'd0 && res_limit == 32'd0);

  // R10
  action_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault == 3'd0 |->
      (res_set_in_busy || res_clr_out_busy) && !(res_clr_out_busy && res_write_link));
endmodule

bind task_switch_gatekeeper tsg_checker #(.MIN_TSS_LIMIT(MIN_TSS_LIMIT)) u_chk (.*);

// File: tb/tb_task_switch_gatekeeper.sv
module tb_task_switch_gatekeeper;
  localparam int CLK_NS = 10;
  localparam int Q = CLK_NS / 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_desc = '0;
  logic [1:0]  in_kind = '0, in_cpl = '0, in_rpl = '0;
  logic        in_ti = 1'b0;
  logic        fet_valid, fet_ready = 1'b1;
  logic [15:0] fet_sel;
  logic        res_valid, res_ready = 1'b1;
  logic [2:0]  res_fault;
  logic [31:0] res_base, res_limit;
  logic        res_set_in_busy, res_clr_out_busy, res_write_link;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit bp_en = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  task_switch_gatekeeper dut (.*);

  // ---------------- reference model ----------------
  int          m_st = 0;   // 0 idle, 1 fetch, 2 wait inner, 3 result
  logic [2:0]  m_fault;
  logic [31:0] m_base, m_lim;
  logic        m_set, m_clr, m_lnk;
  logic [15:0] m_sel = '0;
  logic [1:0]  m_kind;

  function automatic logic [31:0] b_base(logic [63:0] d);
    return {d[63:56], d[39:32], d[31:16]};
  endfunction

  function automatic logic [31:0] b_lim(logic [63:0] d);
    logic [31:0] raw;
    raw = {12'd0, d[51:48], d[15:0]};
    return d[55] ? (raw * 4096 + 4095) : raw;
  endfunction

  // returns -1 when a gate passes and a second fetch is due
  function automatic int b_eval(logic [63:0] d, logic [1:0] kind, logic [1:0] cpl,
                                logic [1:0] rpl, bit ti, bit inner);
    bit tss, gate, ent, privok;
    tss    = !d[44] && (d[43:40] == 4'b1001 || d[43:40] == 4'b1011);
    gate   = !d[44] && d[43:40] == 4'b0101;
    ent    = (kind != 2'd3);
    privok = (d[46:45] >= cpl) && (d[46:45] >= rpl);
    if (!inner && gate && ent) begin
      if (!privok) return 2;
      if (!d[47])  return 3;
      return -1;
    end
    if (!inner && kind == 2'd2) return 1;
    if (ti) return 5;
    if (!tss) return 1;
    if (!inner && ent && !privok) return 2;
    if (!d[47]) return 3;
    if (b_lim(d) < 32'h67) return 4;
    if (ent && d[41]) return 6;
    if (!ent && !d[41]) return 7;
    return 0;
  endfunction

  function automatic string ftag(logic [2:0] f);
    case (f)
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R4";
      3'd6, 3'd7: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic load_res(int f, logic [63:0] d, logic [1:0] kind);
    bit ok;
    ok      = (f == 0);
    m_fault = 3'(f);
    m_base  = ok ? b_base(d) : 32'd0;
    m_lim   = ok ? b_lim(d) : 32'd0;
    m_set   = ok && kind != 2'd3;
    m_clr   = ok && (kind == 2'd0 || kind == 2'd3);
    m_lnk   = ok && (kind == 2'd1 || kind == 2'd2);
  endtask

  always @(posedge clk) begin
    int f;
    if (!rst_n) begin
      m_st = 0;
    end else begin
      case (m_st)
        0: if (in_valid) begin
          f = b_eval(in_desc, in_kind, in_cpl, in_rpl, in_ti, 1'b0);
          if (f < 0) begin
            m_sel = in_desc[31:16]; m_kind = in_kind; m_st = 1;
          end else begin
            load_res(f, in_desc, in_kind); m_st = 3;
          end
        end
        1: if (fet_ready) m_st = 2;
        2: if (in_valid) begin
          f = b_eval(in_desc, m_kind, 2'd0, 2'd0, m_sel[2], 1'b1);
          load_res(f, in_desc, m_kind); m_st = 3;
        end
        default: if (res_ready) m_st = 0;
      endcase
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 in_ready", 32'(in_ready), 32'(m_st == 0 || m_st == 2));
      chk("R2 fet_valid", 32'(fet_valid), 32'(m_st == 1));
      chk("R2 res_valid", 32'(res_valid), 32'(m_st == 3));
      if (m_st == 1) chk("R12 fet_sel", 32'(fet_sel), 32'(m_sel));
      if (m_st == 3) begin
        chk({ftag(m_fault), " fault"}, 32'(res_fault), 32'(m_fault));
        chk("R3 base", res_base, m_base);
        chk("R3 limit", res_limit, m_lim);
        chk("R10 actions", {29'd0, res_set_in_busy, res_clr_out_busy, res_write_link},
            {29'd0, m_set, m_clr, m_lnk});
      end
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [63:0] mk_tss(logic [31:0] base, logic [19:0] lim, bit g,
                                         logic [1:0] dpl, bit p, bit busy);
    return {base[31:24], g, 3'b000, lim[19:16], p, dpl, 1'b0, 1'b1, 1'b0, busy, 1'b1,
            base[23:16], base[15:0], lim[15:0]};
  endfunction

  function automatic logic [63:0] mk_gate(logic [15:0] sel, logic [1:0] dpl, bit p);
    return {16'h0000, p, dpl, 1'b0, 4'b0101, 8'h00, sel, 16'h0000};
  endfunction

  localparam logic [63:0] S_BIT = 64'h0000_1000_0000_0000;

  task automatic send(logic [63:0] d, logic [1:0] kind, logic [1:0] cpl,
                      logic [1:0] rpl, bit ti);
    bit hs;
    in_valid = 1'b1; in_desc = d; in_kind = kind; in_cpl = cpl; in_rpl = rpl; in_ti = ti;
    forever begin
      @(negedge clk); hs = in_ready;
      @(posedge clk); #(Q);
      if (hs) break;
    end
    in_valid = 1'b0;
  endtask

  logic [15:0] lfsr = 16'hACE1;
  initial begin
    forever begin
      @(posedge clk); #(Q);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      res_ready = bp_en ? lfsr[0] : 1'b1;
      fet_ready = bp_en ? lfsr[3] : 1'b1;
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset res_valid", 32'(res_valid), 32'd0);
    chk("R1 reset fet_valid", 32'(fet_valid), 32'd0);
    chk("R1 reset in_ready", 32'(in_ready), 32'd1);
    @(posedge clk); #(Q); rst_n = 1'b1;
    @(posedge clk); #(Q);

    // R3 R10 direct jump, byte granularity, limit exactly at minimum
    send(mk_tss(32'h1234_5678, 20'h00067, 0, 2'd3, 1, 0), 2'd0, 2'd3, 2'd0, 0);
    // R3 R10 call with 4K granularity
    send(mk_tss(32'hCAFE_0000, 20'h00001, 1, 2'd0, 1, 0), 2'd1, 2'd0, 2'd0, 0);
    // R10 nested return to busy TSS
    send(mk_tss(32'h0000_4000, 20'h00100, 0, 2'd0, 1, 1), 2'd3, 2'd3, 2'd3, 0);
    // R9 return to idle TSS
    send(mk_tss(32'h0000_4000, 20'h00100, 0, 2'd0, 1, 0), 2'd3, 2'd0, 2'd0, 0);
    // R9 jump to busy TSS
    send(mk_tss(32'h0000_5000, 20'h00100, 0, 2'd0, 1, 1), 2'd0, 2'd0, 2'd0, 0);
    // R8 limit one below minimum
    send(mk_tss(32'h0000_6000, 20'h00066, 0, 2'd0, 1, 0), 2'd0, 2'd0, 2'd0, 0);
    // R4 local table on direct beat, with busy too (R11 priority)
    send(mk_tss(32'h0000_7000, 20'h00100, 0, 2'd0, 1, 1), 2'd1, 2'd0, 2'd0, 1);
    // R5 segment descriptor, and interrupt naming a TSS
    send(mk_tss(32'h0, 20'h100, 0, 2'd0, 1, 0) | S_BIT, 2'd0, 2'd0, 2'd0, 0);
    send(mk_tss(32'h0, 20'h100, 0, 2'd3, 1, 0), 2'd2, 2'd0, 2'd0, 1);
    // R5 return given a gate
    send(mk_gate(16'h0028, 2'd3, 1), 2'd3, 2'd0, 2'd0, 0);
    // R6 direct privilege failure through rpl
    send(mk_tss(32'h0, 20'h100, 0, 2'd1, 1, 0), 2'd0, 2'd0, 2'd2, 0);
    // R7 TSS not present, privilege fine
    send(mk_tss(32'h0, 20'h100, 0, 2'd3, 0, 0), 2'd1, 2'd3, 2'd0, 0);
    // R12 R6 gate via call; inner DPL 0 below CPL 3 is ignored
    send(mk_gate(16'h0028, 2'd3, 1), 2'd1, 2'd3, 2'd3, 1);
    send(mk_tss(32'hABCD_0100, 20'h00200, 0, 2'd0, 1, 0), 2'd3, 2'd3, 2'd3, 1);
    // R6 gate selector rpl 3 ignored on the inner beat
    send(mk_gate(16'h002B, 2'd2, 1), 2'd0, 2'd2, 2'd1, 0);
    send(mk_tss(32'h0001_0000, 20'h00067, 0, 2'd0, 1, 0), 2'd0, 2'd0, 2'd0, 0);
    // R4 gate selector names local table
    send(mk_gate(16'h002C, 2'd0, 1), 2'd2, 2'd0, 2'd0, 0);
    send(mk_tss(32'h0001_0000, 20'h00067, 0, 2'd0, 1, 0), 2'd0, 2'd0, 2'd0, 0);
    // R9 gate to busy TSS
    send(mk_gate(16'h0030, 2'd0, 1), 2'd2, 2'd0, 2'd0, 0);
    send(mk_tss(32'h0001_0000, 20'h00100, 0, 2'd0, 1, 1), 2'd0, 2'd0, 2'd0, 0);
    // R6 gate privilege failure, R7 gate absent
    send(mk_gate(16'h0030, 2'd1, 1), 2'd1, 2'd2, 2'd0, 0);
    send(mk_gate(16'h0030, 2'd3, 0), 2'd1, 2'd0, 2'd0, 0);
    // R7 inner TSS absent
    send(mk_gate(16'h0038, 2'd3, 1), 2'd0, 2'd0, 2'd0, 0);
    send(mk_tss(32'h0, 20'h100, 0, 2'd3, 0, 0), 2'd0, 2'd0, 2'd0, 0);

    // R1 back-pressure with mixed patterns
    bp_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [63:0] d;
      int sel;
      sel = $urandom_range(0, 3);
      if (sel == 1)
        d = mk_gate(16'($urandom), 2'($urandom), ($urandom_range(0, 7) != 0));
      else
        d = mk_tss($urandom, ($urandom_range(0, 1) != 0) ? 20'($urandom_range(96, 110)) : 20'($urandom),
                   $urandom_range(0, 1) != 0, 2'($urandom), ($urandom_range(0, 7) != 0),
                   $urandom_range(0, 1) != 0);
      if (sel == 2) d = d | S_BIT;
      send(d, 2'($urandom), 2'($urandom), 2'($urandom), ($urandom_range(0, 5) == 0));
    end
    bp_en = 1'b0;
    repeat (10) @(posedge clk);
    finish_run();
  end
endmodule